// File: doc/BRIEF.md
# Triggered Command-Set Sequencer

The block holds a small bank of command sets. Each set reserves room for sixteen command slots, of which a parameterised number are actually built. Every slot carries a message-ID word, a target address and a data word. A host on a simple register port loads slots, marks which of them take part through a per-set enable mask, and then starts the set. Starting is a two-step affair. A mode-enable bit must already be on before a trigger bit is accepted. A transfer begins on the trigger's rising edge.

Once a set runs, its enabled commands leave on a valid/ready output stream in ascending slot order, one command per handshake. The consumer applies back-pressure by holding `cmd_ready` low. While `cmd_valid` is high and `cmd_ready` is low, every field on the stream stays frozen until the handshake. Commands whose message-ID has the response-required flag wait for an acknowledgement on a separate tagged return input. All other commands count as done as soon as the handshake takes place. When every enabled command of a set is done, the set's bit in a shared interrupt status register goes high. That bit drives `irq` through a per-set mask and is cleared by writing a one to it.

Host map, in bytes: set s occupies 672 bytes from s*672. Within a set, offset 0x00 is control (bit 16 mode enable, bit 24 trigger), 0x04 is the slot enable mask (bit j = slot j), and 0x08 is a read-only configuration word whose bits 31:27 give the number of built slots. Slot j starts at 0x20 + 24*j and holds four words: +0 message-ID, +4 address, +8 data, and +12 status (read-only; bit 8 issued, bit 16 complete). Above all the sets, at NUM_SETS*672, sit three words: +0 interrupt mask, +4 interrupt status (read-only) and +8 clear (write one to clear). In a message-ID, bits 7:0 hold the length (8), bit 8 requests a response and bit 16 marks a write.

Top module: `cmdset_sequencer`

## Requirements
- R1: After reset, no command is offered (`cmd_valid` low), `irq` is low, and the control, enable, interrupt status and interrupt mask registers read zero. The configuration word reads SLOTS in bits 31:27.
- R2: A slot's message-ID, address and data words read back what was written. Writes to reserved slots at or above SLOTS are dropped and read zero. Enable mask bits at or above SLOTS read zero. The stream never carries a slot index at or above SLOTS.
- R3: The trigger bit (control bit 24) is stored only if mode enable (bit 16) was already set before the write. A single write that sets both bits from a cleared state leaves trigger off and starts nothing. A set starts when trigger goes from 0 to 1 while the set is idle.
- R4: Mode enable cannot be cleared while trigger stays set; such a write keeps mode enable at 1. Clearing trigger first and then mode enable returns control to zero.
- R5: A running set offers exactly its enabled slots, in ascending slot order. Each offer carries the slot's message-ID, address and data and is tagged with its set and slot indices.
- R6: While `cmd_valid` is high and `cmd_ready` is low, the offered command and its tags stay unchanged. One command is consumed per handshake and is not offered again.
- R7: A slot's status shows bit 8 once its command has been handshaked. A command without the response flag (message-ID bit 8) shows bit 16 at the same time. A command with the flag shows bit 16 only after an acknowledgement carrying its set and slot arrives.
- R8: A set's interrupt status bit goes high only when all its enabled commands are complete. A set started with an empty enable mask completes right away.
- R9: `irq` is high exactly when some status bit and its mask bit are both set. Writing a one to the clear word drops the matching status bit.
- R10: Writing zero to a set's enable word erases every slot of that set: the message-ID, address, data and status words then read zero.
- R11: When several sets have commands waiting, the lowest-numbered set is served first. A command already held under back-pressure is completed before this priority is re-evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | HAW | Register byte address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr (combinational) |
| cmd_valid | output | 1 | Command offered on the stream |
| cmd_ready | input | 1 | Consumer accepts the offered command |
| cmd_set | output | SET_W | Set index of the offered command |
| cmd_slot | output | 4 | Slot index of the offered command |
| cmd_msgid | output | 32 | Message-ID word of the offered command |
| cmd_addr | output | AW | Target address of the offered command |
| cmd_data | output | DW | Data of the offered command |
| ack_valid | input | 1 | Acknowledgement for a response-required command |
| ack_set | input | SET_W | Set index of the acknowledged command |
| ack_slot | input | 4 | Slot index of the acknowledged command |
| irq | output | 1 | Masked completion interrupt |

## Verification
A stale issued mask in a set shows up as a command that is offered twice or skipped in the captured stream. This is visible on the cycle right after the faulty handshake. A completion flag set too early or too late shows up as an interrupt status bit that rises while an acknowledgement is still owed, or that never rises. Reading the slot status words back at that point exposes which command is wrong. A broken hold path shows up as changing stream fields under back-pressure, within one cycle of the stall. A broken priority shows up as a reordered sequence when two sets run together.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int SLOTS_RSV     = 16;
  localparam int SLOT_IDX_W    = 4;
  localparam int SET_STRIDE    = 672;
  localparam int SLOT_STRIDE   = 24;
  localparam int SLOT_BASE     = 32;
  localparam int OFF_CTRL      = 0;
  localparam int OFF_EN        = 4;
  localparam int OFF_CFG       = 8;
  localparam int W_MSGID       = 0;
  localparam int W_ADDR        = 4;
  localparam int W_DATA        = 8;
  localparam int W_STAT        = 12;
  localparam int CTRL_MODE_BIT = 16;
  localparam int CTRL_TRIG_BIT = 24;
  localparam int MSG_RESP_BIT  = 8;
  localparam int STAT_ISS_BIT  = 8;
  localparam int STAT_CMP_BIT  = 16;
  localparam int CFG_CNT_LSB   = 27;
  localparam int IRQ_MASK_OFF  = 0;
  localparam int IRQ_STAT_OFF  = 4;
  localparam int IRQ_CLR_OFF   = 8;
endpackage

// File: rtl/cs_bank.sv
module cs_bank
  import cs_pkg::*;
#(
  parameter int SET_IDX = 0,
  parameter int SLOTS   = 8,
  parameter int HAW     = 12,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [HAW-1:0]        waddr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  issue_fire,
  input  logic [SLOT_IDX_W-1:0] issue_slot,
  input  logic                  ack_fire,
  input  logic [SLOT_IDX_W-1:0] ack_slot,
  input  logic [SLOT_IDX_W-1:0] sel_slot,
  output logic [31:0]           sel_msgid,
  output logic [AW-1:0]         sel_addr,
  output logic [DW-1:0]         sel_data,
  output logic                  pend_any,
  output logic [SLOT_IDX_W-1:0] pend_slot,
  output logic                  busy,
  output logic                  done
);
  localparam int BASE = SET_IDX * SET_STRIDE;
  localparam int SW   = SLOT_IDX_W;

  logic [31:0]   msg_q [SLOTS];
  logic [AW-1:0] adr_q [SLOTS];
  logic [DW-1:0] dat_q [SLOTS];
  logic [SLOTS-1:0] en_q, iss_q, cmp_q, pend;
  logic [SLOTS-1:0] hit_msg, hit_adr, hit_dat, hit_sts;
  logic mode_q, trig_q, busy_q;
  logic mode_d, trig_d, start, forget;
  logic hit, ctrl_hit, en_hit, cfg_hit;
  logic [HAW:0]   addr_x;
  logic [HAW-1:0] off;

  assign addr_x   = {1'b0, waddr};
  assign hit      = (addr_x >= (HAW+1)'(BASE)) && (addr_x < (HAW+1)'(BASE + SET_STRIDE));
  assign off      = waddr - HAW'(BASE);
  assign ctrl_hit = hit && (off == HAW'(OFF_CTRL));
  assign en_hit   = hit && (off == HAW'(OFF_EN));
  assign cfg_hit  = hit && (off == HAW'(OFF_CFG));

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      hit_msg[j] = hit && (off == HAW'(SLOT_BASE + j*SLOT_STRIDE + W_MSGID));
      hit_adr[j] = hit && (off == HAW'(SLOT_BASE + j*SLOT_STRIDE + W_ADDR));
      hit_dat[j] = hit && (off == HAW'(SLOT_BASE + j*SLOT_STRIDE + W_DATA));
      hit_sts[j] = hit && (off == HAW'(SLOT_BASE + j*SLOT_STRIDE + W_STAT));
    end
  end

  // Control: trigger needs mode already on; mode sticks while trigger stays on.
  always_comb begin
    trig_d = trig_q;
    mode_d = mode_q;
    if (wr && ctrl_hit) begin
      trig_d = wdata[CTRL_TRIG_BIT] & mode_q;
      mode_d = wdata[CTRL_MODE_BIT] | (mode_q & wdata[CTRL_TRIG_BIT]);
    end
  end

  assign start  = trig_d & ~trig_q & ~busy_q;
  assign forget = wr && en_hit && (wdata == '0);
  assign done   = busy_q && ((cmp_q & en_q) == en_q);
  assign busy   = busy_q;
  assign pend   = busy_q ? (en_q & ~iss_q) : '0;
  assign pend_any = |pend;

  always_comb begin
    pend_slot = '0;
    for (int j = SLOTS-1; j >= 0; j--) begin
      if (pend[j]) pend_slot = SW'(j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      trig_q <= 1'b0;
      busy_q <= 1'b0;
      en_q   <= '0;
      iss_q  <= '0;
      cmp_q  <= '0;
      for (int j = 0; j < SLOTS; j++) begin
        msg_q[j] <= '0;
        adr_q[j] <= '0;
        dat_q[j] <= '0;
      end
    end else begin
      mode_q <= mode_d;
      trig_q <= trig_d;
      if (wr && en_hit) en_q <= wdata[SLOTS-1:0];
      for (int j = 0; j < SLOTS; j++) begin
        if (forget) begin
          msg_q[j] <= '0;
          adr_q[j] <= '0;
          dat_q[j] <= '0;
        end else begin
          if (wr && hit_msg[j]) msg_q[j] <= wdata;
          if (wr && hit_adr[j]) adr_q[j] <= wdata[AW-1:0];
          if (wr && hit_dat[j]) dat_q[j] <= wdata[DW-1:0];
        end
      end
      if (start || forget) begin
        iss_q <= '0;
        cmp_q <= '0;
      end else begin
        for (int j = 0; j < SLOTS; j++) begin
          if (issue_fire && issue_slot == SW'(j)) begin
            iss_q[j] <= 1'b1;
            if (!msg_q[j][MSG_RESP_BIT]) cmp_q[j] <= 1'b1;
          end
          if (ack_fire && ack_slot == SW'(j) && iss_q[j] && busy_q) cmp_q[j] <= 1'b1;
        end
      end
      if (start) busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
    end
  end

  always_comb begin
    sel_msgid = '0;
    sel_addr  = '0;
    sel_data  = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (sel_slot == SW'(j)) begin
        sel_msgid = msg_q[j];
        sel_addr  = adr_q[j];
        sel_data  = dat_q[j];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[CTRL_TRIG_BIT] = trig_q;
      rdata[CTRL_MODE_BIT] = mode_q;
    end
    if (en_hit)  rdata[SLOTS-1:0] = en_q;
    if (cfg_hit) rdata[31:CFG_CNT_LSB] = 5'(SLOTS);
    for (int j = 0; j < SLOTS; j++) begin
      if (hit_msg[j]) rdata = msg_q[j];
      if (hit_adr[j]) rdata = 32'(adr_q[j]);
      if (hit_dat[j]) rdata = 32'(dat_q[j]);
      if (hit_sts[j]) begin
        rdata[STAT_ISS_BIT] = iss_q[j];
        rdata[STAT_CMP_BIT] = cmp_q[j];
      end
    end
  end
endmodule

// File: rtl/cs_arb.sv
module cs_arb
  import cs_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_SETS-1:0]                   pend_any,
  input  logic [NUM_SETS-1:0][SLOT_IDX_W-1:0]   pend_slot,
  input  logic                                  ready,
  output logic                                  valid,
  output logic [SET_W-1:0]                      set_o,
  output logic [SLOT_IDX_W-1:0]                 slot_o,
  output logic                                  fire
);
  logic                  hold_q;
  logic [SET_W-1:0]      hset_q, pset;
  logic [SLOT_IDX_W-1:0] hslot_q, pslot;

  // Lowest-numbered set with work wins.
  always_comb begin
    pset  = '0;
    pslot = '0;
    for (int s = NUM_SETS-1; s >= 0; s--) begin
      if (pend_any[s]) begin
        pset  = SET_W'(s);
        pslot = pend_slot[s];
      end
    end
  end

  assign valid  = hold_q | (|pend_any);
  assign set_o  = hold_q ? hset_q  : pset;
  assign slot_o = hold_q ? hslot_q : pslot;
  assign fire   = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      hset_q  <= '0;
      hslot_q <= '0;
    end else begin
      hold_q  <= valid & ~ready;
      hset_q  <= set_o;
      hslot_q <= slot_o;
    end
  end
endmodule

// File: rtl/cs_irq.sv
module cs_irq
  import cs_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int HAW      = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [HAW-1:0]      waddr,
  input  logic [31:0]         wdata,
  input  logic [NUM_SETS-1:0] done,
  output logic [31:0]         rdata,
  output logic [NUM_SETS-1:0] stat,
  output logic                irq
);
  localparam int GBASE = NUM_SETS * SET_STRIDE;

  logic [NUM_SETS-1:0] mask_q, stat_q, clr;
  logic mask_hit, stat_hit, clr_hit;
  logic unused_wbits;

  assign mask_hit = (waddr == HAW'(GBASE + IRQ_MASK_OFF));
  assign stat_hit = (waddr == HAW'(GBASE + IRQ_STAT_OFF));
  assign clr_hit  = (waddr == HAW'(GBASE + IRQ_CLR_OFF));
  assign clr      = (wr && clr_hit) ? wdata[NUM_SETS-1:0] : '0;
  assign unused_wbits = &{1'b0, wdata[31:NUM_SETS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr && mask_hit) mask_q <= wdata[NUM_SETS-1:0];
      stat_q <= (stat_q & ~clr) | done;
    end
  end

  always_comb begin
    rdata = '0;
    if (mask_hit) rdata[NUM_SETS-1:0] = mask_q;
    if (stat_hit) rdata[NUM_SETS-1:0] = stat_q;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask_q);
endmodule

// File: rtl/cmdset_sequencer.sv
module cmdset_sequencer
  import cs_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SLOTS    = 8,
  parameter int HAW      = 12,
  parameter int AW       = 32,
  parameter int DW       = 32,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic [HAW-1:0]        host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [SET_W-1:0]      cmd_set,
  output logic [SLOT_IDX_W-1:0] cmd_slot,
  output logic [31:0]           cmd_msgid,
  output logic [AW-1:0]         cmd_addr,
  output logic [DW-1:0]         cmd_data,
  input  logic                  ack_valid,
  input  logic [SET_W-1:0]      ack_set,
  input  logic [SLOT_IDX_W-1:0] ack_slot,
  output logic                  irq
);
  logic [NUM_SETS-1:0]                 pend_any, busy_vec, done_vec, irq_stat;
  logic [NUM_SETS-1:0][SLOT_IDX_W-1:0] pend_slot;
  logic [31:0]   bank_rdata [NUM_SETS];
  logic [31:0]   bank_msgid [NUM_SETS];
  logic [AW-1:0] bank_addr  [NUM_SETS];
  logic [DW-1:0] bank_data  [NUM_SETS];
  logic [31:0]   irq_rdata;
  logic          fire;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    cs_bank #(
      .SET_IDX(s), .SLOTS(SLOTS), .HAW(HAW), .AW(AW), .DW(DW)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (host_wr),
      .waddr      (host_addr),
      .wdata      (host_wdata),
      .rdata      (bank_rdata[s]),
      .issue_fire (fire && (cmd_set == SET_W'(s))),
      .issue_slot (cmd_slot),
      .ack_fire   (ack_valid && (ack_set == SET_W'(s))),
      .ack_slot   (ack_slot),
      .sel_slot   (cmd_slot),
      .sel_msgid  (bank_msgid[s]),
      .sel_addr   (bank_addr[s]),
      .sel_data   (bank_data[s]),
      .pend_any   (pend_any[s]),
      .pend_slot  (pend_slot[s]),
      .busy       (busy_vec[s]),
      .done       (done_vec[s])
    );
  end

  cs_arb #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_any  (pend_any),
    .pend_slot (pend_slot),
    .ready     (cmd_ready),
    .valid     (cmd_valid),
    .set_o     (cmd_set),
    .slot_o    (cmd_slot),
    .fire      (fire)
  );

  cs_irq #(.NUM_SETS(NUM_SETS), .HAW(HAW)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (host_wr),
    .waddr (host_addr),
    .wdata (host_wdata),
    .done  (done_vec),
    .rdata (irq_rdata),
    .stat  (irq_stat),
    .irq   (irq)
  );

  always_comb begin
    cmd_msgid  = '0;
    cmd_addr   = '0;
    cmd_data   = '0;
    host_rdata = irq_rdata;
    for (int s = 0; s < NUM_SETS; s++) begin
      host_rdata = host_rdata | bank_rdata[s];
      if (cmd_set == SET_W'(s)) begin
        cmd_msgid = bank_msgid[s];
        cmd_addr  = bank_addr[s];
        cmd_data  = bank_data[s];
      end
    end
  end
endmodule

// File: rtl/cs_chk.sv
module cs_chk
  import cs_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SLOTS    = 8,
  parameter int SET_W    = 2,
  parameter int AW       = 32,
  parameter int DW       = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [SET_W-1:0]      cmd_set,
  input logic [SLOT_IDX_W-1:0] cmd_slot,
  input logic [31:0]           cmd_msgid,
  input logic [AW-1:0]         cmd_addr,
  input logic [DW-1:0]         cmd_data,
  input logic [NUM_SETS-1:0]   busy_vec,
  input logic [NUM_SETS-1:0]   irq_stat
);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_set) && $stable(cmd_slot)
      && $stable(cmd_msgid) && $stable(cmd_addr) && $stable(cmd_data));

  assert_no_reoffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=>
      !(cmd_valid && cmd_set == $past(cmd_set) && cmd_slot == $past(cmd_slot)));

  assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_slot < SLOT_IDX_W'(SLOTS)));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_done
    assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_vec[s]) |-> irq_stat[s]);
  end
endmodule

bind cmdset_sequencer cs_chk #(
  .NUM_SETS(NUM_SETS), .SLOTS(SLOTS), .SET_W(SET_W), .AW(AW), .DW(DW)
) u_cs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_set   (cmd_set),
  .cmd_slot  (cmd_slot),
  .cmd_msgid (cmd_msgid),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .busy_vec  (busy_vec),
  .irq_stat  (irq_stat)
);

// File: tb/tb_cmdset_sequencer.sv
module tb_cmdset_sequencer;
  localparam int NS = 3;
  localparam int SL = 8;
  localparam int G  = NS * 672;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_set;
  logic [3:0] cmd_slot;
  logic [31:0] cmd_msgid, cmd_addr, cmd_data;
  logic ack_valid = 1'b0;
  logic [1:0] ack_set = '0;
  logic [3:0] ack_slot = '0;
  logic irq;

  always #5 clk = ~clk;

  cmdset_sequencer dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_set(cmd_set), .cmd_slot(cmd_slot),
    .cmd_msgid(cmd_msgid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .ack_valid(ack_valid), .ack_set(ack_set), .ack_slot(ack_slot), .irq(irq)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;
  int ready_mode = 0;
  bit ack_auto = 0;
  int obs_cnt = 0;
  int obs_set [512];
  int obs_slot [512];
  logic [31:0] obs_addr [512];
  logic [31:0] obs_data [512];
  int aq_set [512];
  int aq_slot [512];
  int aq_head = 0, aq_tail = 0;
  logic [31:0] e_msg [SL];
  logic [31:0] e_adr [SL];
  logic [31:0] e_dat [SL];

  function automatic int slot_a(int s, int j, int k);
    return s*672 + 32 + 24*j + 4*k;
  endfunction
  function automatic logic [31:0] exp_status(bit en);
    return en ? 32'h0001_0100 : 32'h0;
  endfunction
  function automatic int popc(logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask
  task automatic hw(int a, logic [31:0] d);
    @(negedge clk);
    host_addr = 12'(a); host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask
  task automatic hr(int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = 12'(a);
    #2 d = host_rdata;
  endtask
  task automatic start_set(int s);
    hw(s*672, 32'h0001_0000);
    hw(s*672, 32'h0101_0000);
  endtask
  task automatic retire_set(int s);
    hw(s*672, 32'h0001_0000);
    hw(s*672, 32'h0);
  endtask
  task automatic load(int s, int j, logic [31:0] m, logic [31:0] a, logic [31:0] d);
    hw(slot_a(s, j, 0), m);
    hw(slot_a(s, j, 1), a);
    hw(slot_a(s, j, 2), d);
  endtask
  task automatic wait_irq(int s, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 400 && !ok; i++) begin
      hr(G + 4, v);
      if (v[s]) ok = 1;
    end
  endtask
  task automatic report;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  // Stream consumer and acknowledgement source
  initial begin
    forever begin
      @(negedge clk);
      cmd_ready = (ready_mode == 1) || (ready_mode == 2 && ($urandom % 3) != 0);
      ack_valid = 1'b0;
      if (ack_auto && aq_head != aq_tail && ($urandom % 2) == 1) begin
        ack_valid = 1'b1;
        ack_set   = 2'(aq_set[aq_head % 512]);
        ack_slot  = 4'(aq_slot[aq_head % 512]);
        aq_head++;
      end
      #1;
      if (rst_n && cmd_valid && cmd_ready) begin
        obs_set[obs_cnt % 512]  = int'(cmd_set);
        obs_slot[obs_cnt % 512] = int'(cmd_slot);
        obs_addr[obs_cnt % 512] = cmd_addr;
        obs_data[obs_cnt % 512] = cmd_data;
        obs_cnt++;
        if (cmd_msgid[8]) begin
          aq_set[aq_tail % 512]  = int'(cmd_set);
          aq_slot[aq_tail % 512] = int'(cmd_slot);
          aq_tail++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0;
    int base;
    bit ok;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 cmd_valid", 32'(cmd_valid), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    hr(0, v);       chk("R1 ctrl", v, 32'h0);
    hr(4, v);       chk("R1 enable", v, 32'h0);
    hr(8, v);       chk("R1 config", v, 32'(SL) << 27);
    hr(G + 4, v);   chk("R1 irq status", v, 32'h0);
    hr(G, v);       chk("R1 irq mask", v, 32'h0);

    // R2 readback and reserved slots
    load(1, 3, 32'h0001_0008, 32'hCAFE_0003, 32'h5555_AAAA);
    hr(slot_a(1, 3, 0), v); chk("R2 msgid", v, 32'h0001_0008);
    hr(slot_a(1, 3, 1), v); chk("R2 addr", v, 32'hCAFE_0003);
    hr(slot_a(1, 3, 2), v); chk("R2 data", v, 32'h5555_AAAA);
    hw(slot_a(1, SL, 1), 32'hDEAD_BEEF);
    hr(slot_a(1, SL, 1), v); chk("R2 reserved slot", v, 32'h0);
    hw(672 + 4, 32'h0000_FFFF);
    hr(672 + 4, v); chk("R2 enable width", v, 32'h0000_00FF);

    // R10 forget
    hw(672 + 4, 32'h0);
    hr(slot_a(1, 3, 1), v); chk("R10 addr erased", v, 32'h0);
    hr(slot_a(1, 3, 0), v); chk("R10 msgid erased", v, 32'h0);

    // R3 start sequence
    ack_auto = 1; ready_mode = 1;
    load(0, 0, 32'h0001_0008, 32'hA0A0_0000, 32'h0000_1234);
    hw(4, 32'h1);
    base = obs_cnt;
    hw(0, 32'h0101_0000);
    hr(0, v); chk("R3 trigger rejected", v, 32'h0001_0000);
    repeat (5) @(negedge clk);
    chk("R3 no start", 32'(obs_cnt - base), 32'h0);
    hw(0, 32'h0101_0000);
    repeat (6) @(negedge clk);
    chk("R3 started", 32'(obs_cnt - base), 32'h1);
    chk("R5 addr", obs_addr[base % 512], 32'hA0A0_0000);
    chk("R5 data", obs_data[base % 512], 32'h0000_1234);
    hr(slot_a(0, 0, 3), v); chk("R7 no-resp status", v, exp_status(1));
    hr(G + 4, v); chk("R8 set0 done", v, 32'h1);
    #1 chk("R9 masked", 32'(irq), 32'h0);
    hw(G, 32'h7);
    #1 chk("R9 irq on", 32'(irq), 32'h1);
    hw(G + 8, 32'h1);
    hr(G + 4, v); chk("R9 cleared", v, 32'h0);
    #1 chk("R9 irq off", 32'(irq), 32'h0);

    // R4 retire ordering
    hw(0, 32'h0100_0000);
    hr(0, v); chk("R4 mode held", v, 32'h0101_0000);
    hw(0, 32'h0001_0000);
    hr(0, v); chk("R4 trig cleared", v, 32'h0001_0000);
    hw(0, 32'h0);
    hr(0, v); chk("R4 ctrl zero", v, 32'h0);

    // R7 / R6 response-required with back-pressure
    ready_mode = 0; ack_auto = 0;
    load(2, 1, 32'h0001_0108, 32'hB000_0001, 32'h1111_0001);
    load(2, 2, 32'h0001_0008, 32'hB000_0002, 32'h1111_0002);
    hw(2*672 + 4, 32'h6);
    start_set(2);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 valid under stall", 32'(cmd_valid), 32'h1);
    chk("R5 first slot", {cmd_set, cmd_slot}, {2'd2, 4'd1});
    a0 = cmd_addr;
    hr(slot_a(2, 1, 3), v); chk("R7 not issued", v, 32'h0);
    repeat (3) @(negedge clk);
    #1 chk("R6 addr stable", cmd_addr, a0);
    ready_mode = 1;
    repeat (5) @(negedge clk);
    ready_mode = 0;
    hr(slot_a(2, 1, 3), v); chk("R7 issued awaiting ack", v, 32'h0000_0100);
    hr(slot_a(2, 2, 3), v); chk("R7 no-resp complete", v, exp_status(1));
    hr(G + 4, v); chk("R8 not done before ack", v & 32'h4, 32'h0);
    ack_auto = 1;
    repeat (8) @(negedge clk);
    hr(slot_a(2, 1, 3), v); chk("R7 acked", v, exp_status(1));
    hr(G + 4, v); chk("R8 set2 done", v & 32'h4, 32'h4);
    hw(G + 8, 32'h4);
    retire_set(2);

    // R8 empty mask
    base = obs_cnt;
    start_set(1);
    repeat (4) @(negedge clk);
    hr(G + 4, v); chk("R8 empty completes", v & 32'h2, 32'h2);
    chk("R8 empty no offers", 32'(obs_cnt - base), 32'h0);
    hw(G + 8, 32'h2);
    retire_set(1);

    // R11 priority with a held command
    load(0, 0, 32'h0001_0008, 32'h0000_0A00, 32'h0);
    load(0, 1, 32'h0001_0008, 32'h0000_0A01, 32'h0);
    load(1, 0, 32'h0001_0008, 32'h0000_0B00, 32'h0);
    load(1, 1, 32'h0001_0008, 32'h0000_0B01, 32'h0);
    hw(4, 32'h3);
    hw(672 + 4, 32'h3);
    base = obs_cnt;
    start_set(1);
    start_set(0);
    ready_mode = 1;
    repeat (10) @(negedge clk);
    chk("R11 count", 32'(obs_cnt - base), 32'h4);
    chk("R11 first held", obs_addr[(base+0) % 512], 32'h0000_0B00);
    chk("R11 set0 slot0", obs_addr[(base+1) % 512], 32'h0000_0A00);
    chk("R11 set0 slot1", obs_addr[(base+2) % 512], 32'h0000_0A01);
    chk("R11 set1 slot1", obs_addr[(base+3) % 512], 32'h0000_0B01);
    hw(G + 8, 32'h3);
    retire_set(0);
    retire_set(1);

    // Random transfers, R5 R7 R8
    ready_mode = 2;
    for (int it = 0; it < 30; it++) begin
      int s, idx;
      logic [31:0] mask;
      bit sok;
      s = int'($urandom % NS);
      mask = (it % 7 == 3) ? 32'h0 : 32'($urandom % 256);
      for (int j = 0; j < SL; j++) begin
        e_msg[j] = 32'h0001_0008 | (32'($urandom % 2) << 8);
        e_adr[j] = $urandom;
        e_dat[j] = $urandom;
        load(s, j, e_msg[j], e_adr[j], e_dat[j]);
      end
      hw(s*672 + 4, mask);
      base = obs_cnt;
      start_set(s);
      wait_irq(s, ok);
      chk("R8 random completion", 32'(ok), 32'h1);
      chk("R5 random count", 32'(obs_cnt - base), 32'(popc(mask)));
      if (obs_cnt - base == popc(mask)) begin
        idx = base;
        for (int j = 0; j < SL; j++) begin
          if (mask[j]) begin
            chk("R5 random tag", 32'({obs_set[idx % 512][1:0], obs_slot[idx % 512][3:0]}),
                32'({2'(s), 4'(j)}));
            chk("R5 random addr", obs_addr[idx % 512], e_adr[j]);
            chk("R5 random data", obs_data[idx % 512], e_dat[j]);
            idx++;
          end
        end
      end
      sok = 1;
      for (int j = 0; j < SL; j++) begin
        hr(slot_a(s, j, 3), v);
        if (v !== exp_status(mask[j])) sok = 0;
      end
      chk("R7 random status", 32'(sok), 32'h1);
      hw(G + 8, 32'(1) << s);
      retire_set(s);
    end

    finished = 1;
    report();
    $finish;
  end
endmodule